// File: doc/BRIEF.md
# Trigger Final Decision Unit

This block turns a wide vector of algorithm trigger bits and a smaller vector of technical trigger bits into a handful of final-OR decisions, once per bunch-crossing clock. Every input bit, algorithm or technical, first passes through its own programmable prescaler, which lets through one asserted cycle out of every N. It also feeds its own rate counter, which counts asserted cycles over one luminosity segment.

Each final-OR output has an enable mask over all inputs, which selects the prescaled bits that may fire it. It also has a veto mask over the technical triggers: when any veto-enabled technical trigger is asserted, that output is held low for that crossing. A luminosity-segment strobe copies every rate counter into a readback register and restarts the count. Prescale factors and masks are written through a small indexed write port. The readback registers are read through an index input.

In the combined input index space the algorithm bits come first, at indices 0 to N_ALGO-1, and the technical bits follow, at N_ALGO to N_ALGO+N_TECH-1. Technical bit j therefore sits at index N_ALGO+j.

Top module: `fdl_final_decision`

## Requirements
- R1: After reset every final-OR output is 0, every prescale factor and every mask is 0, and every readback value is 0.
- R2: A prescale factor N greater than 0 lets through the Nth, 2Nth, 3Nth and later asserted cycles of its input. Writing a factor restarts that input's phase, so the next pass comes N asserted cycles after the write.
- R3: A prescale factor of 0 blocks its input from every final-OR output.
- R4: final_or[k] is the OR over all inputs whose prescaled pass is asserted and whose enable-mask bit k is set. It appears exactly 2 clock cycles after the input values are applied.
- R5: If any technical trigger is asserted and has veto-mask bit k set, final_or[k] is 0 for that crossing. The veto uses the raw technical bit and ignores that bit's prescaler.
- R6: Each rate counter counts the asserted cycles of its raw input, before prescaling, within the current luminosity segment.
- R7: At a clock edge where seg_strobe is high, each counter value is copied to its readback register and the counter restarts, counting only that edge's input. rd_rate shows the readback register selected by rd_idx.
- R8: A rate counter holds at all-ones instead of wrapping.
- R9: A write with cfg_we high takes effect at the clock edge. cfg_sel 0 writes the prescale factor of input cfg_idx, cfg_sel 1 writes the enable mask of input cfg_idx (bit k for output k), and cfg_sel 2 writes the veto mask of technical bit cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| algo_bits | input | N_ALGO | Algorithm trigger bits |
| tech_bits | input | N_TECH | Technical trigger bits |
| seg_strobe | input | 1 | Luminosity-segment boundary strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Target: 0 prescale, 1 enable mask, 2 veto mask |
| cfg_idx | input | IDX_W | Input index of the write |
| cfg_wdata | input | DATA_W | Factor or mask value |
| rd_idx | input | IDX_W | Readback index |
| rd_rate | output | CNT_W | Readback of the last segment's count |
| final_or | output | N_OUT | Final-OR decisions |

## Verification
The hardest situations to reach from the ports involve counter saturation, prescaler phase and veto timing. Saturation must meet a strobe at the same edge. A prescaler's phase must be cut short by a factor rewrite. A veto must land in the very crossing in which an enabled bit passes. The bench shrinks the counters to 4 bits so that a long run of one held bit reaches all-ones within a few cycles, and it then strobes. It also rewrites factors between random bursts. It runs directed phases for prescale, block and veto, followed by a long seeded random run with random masks and occasional strobes. Every cycle is compared against a bench model that steps the same two-stage timing described by the requirements.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
    typedef enum logic [1:0] {
        CFG_PRESCALE = 2'd0,
        CFG_ENABLE   = 2'd1,
        CFG_VETO     = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/fdl_prescaler.sv
module fdl_prescaler #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PS_W-1:0] factor_in,
    input  logic            bit_in,
    output logic            pass
);
    logic [PS_W-1:0] factor_q;
    logic [PS_W-1:0] phase_q;
    logic            active;

    assign active = bit_in && (factor_q != '0);
    assign pass   = active && (phase_q == factor_q - PS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            factor_q <= '0;
            phase_q  <= '0;
        end else if (load) begin
            factor_q <= factor_in;
            phase_q  <= '0;
        end else if (active) begin
            phase_q <= pass ? '0 : phase_q + PS_W'(1);
        end
    end

    // R2: the phase never reaches the factor
    p_phase_below_factor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (factor_q != '0) |-> (phase_q < factor_q));
endmodule

// File: rtl/fdl_rate_counter.sv
module fdl_rate_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             seg_strobe,
    output logic [CNT_W-1:0] snap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            snap  <= '0;
        end else if (seg_strobe) begin
            snap  <= cnt_q;
            cnt_q <= CNT_W'(bit_in);
        end else if (bit_in && (cnt_q != '1)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    p_restart_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_strobe |=> (cnt_q <= CNT_W'(1)));
    p_saturate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !seg_strobe) |=> (cnt_q == '1));
endmodule

// File: rtl/fdl_or_stage.sv
module fdl_or_stage #(
    parameter int N_IN   = 192,
    parameter int N_TECH = 64,
    parameter int N_OUT  = 8,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic             veto_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [N_OUT-1:0] mask_in,
    input  logic [N_IN-1:0]  pass,
    input  logic [N_TECH-1:0] tech_q,
    output logic [N_OUT-1:0] final_or
);
    logic [N_OUT-1:0] en_q   [N_IN];
    logic [N_OUT-1:0] veto_q [N_TECH];
    logic [N_OUT-1:0] any_hit;
    logic [N_OUT-1:0] veto_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IN; i++)   en_q[i]   <= '0;
            for (int j = 0; j < N_TECH; j++) veto_q[j] <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++)
                if (en_we && cfg_idx == IDX_W'(i)) en_q[i] <= mask_in;
            for (int j = 0; j < N_TECH; j++)
                if (veto_we && cfg_idx == IDX_W'(j)) veto_q[j] <= mask_in;
        end
    end

    always_comb begin
        any_hit  = '0;
        veto_hit = '0;
        for (int i = 0; i < N_IN; i++)
            any_hit = any_hit | (en_q[i] & {N_OUT{pass[i]}});
        for (int j = 0; j < N_TECH; j++)
            veto_hit = veto_hit | (veto_q[j] & {N_OUT{tech_q[j]}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) final_or <= '0;
        else        final_or <= any_hit & ~veto_hit;
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        p_veto_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            veto_hit[k] |=> !final_or[k]);
        p_or_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
            final_or[k] |-> $past(any_hit[k]));
    end
endmodule

// File: rtl/fdl_final_decision.sv
module fdl_final_decision
    import fdl_pkg::*;
#(
    parameter int N_ALGO = 128,
    parameter int N_TECH = 64,
    parameter int N_OUT  = 8,
    parameter int PS_W   = 16,
    parameter int CNT_W  = 16,
    localparam int N_IN   = N_ALGO + N_TECH,
    localparam int IDX_W  = $clog2(N_IN),
    localparam int DATA_W = (PS_W > N_OUT) ? PS_W : N_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ALGO-1:0] algo_bits,
    input  logic [N_TECH-1:0] tech_bits,
    input  logic              seg_strobe,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_rate,
    output logic [N_OUT-1:0]  final_or
);
    cfg_sel_e         sel;
    logic [N_IN-1:0]  in_q;
    logic [N_IN-1:0]  pass;
    logic [CNT_W-1:0] snap [N_IN];

    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= {tech_bits, algo_bits};
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_bit
        fdl_prescaler #(.PS_W(PS_W)) u_ps (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (cfg_we && sel == CFG_PRESCALE && cfg_idx == IDX_W'(i)),
            .factor_in (cfg_wdata[PS_W-1:0]),
            .bit_in    (in_q[i]),
            .pass      (pass[i])
        );
        fdl_rate_counter #(.CNT_W(CNT_W)) u_rc (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_in     (in_q[i]),
            .seg_strobe (seg_strobe),
            .snap       (snap[i])
        );
    end

    fdl_or_stage #(
        .N_IN(N_IN), .N_TECH(N_TECH), .N_OUT(N_OUT), .IDX_W(IDX_W)
    ) u_or (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (cfg_we && sel == CFG_ENABLE),
        .veto_we  (cfg_we && sel == CFG_VETO),
        .cfg_idx  (cfg_idx),
        .mask_in  (cfg_wdata[N_OUT-1:0]),
        .pass     (pass),
        .tech_q   (in_q[N_IN-1:N_ALGO]),
        .final_or (final_or)
    );

    always_comb begin
        rd_rate = '0;
        for (int i = 0; i < N_IN; i++)
            if (rd_idx == IDX_W'(i)) rd_rate = snap[i];
    end

    // R3: a blocked input that is the only enabled source never fires
    p_prescale_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (final_or != '0) |-> $past(pass != '0));
endmodule

// File: tb/fdl_final_decision_tb.sv
module fdl_final_decision_tb;
    localparam int N_ALGO = 6, N_TECH = 4, N_OUT = 4, PS_W = 4, CNT_W = 4;
    localparam int N_IN = N_ALGO + N_TECH;
    localparam int IDX_W = $clog2(N_IN);
    localparam int DATA_W = 4;
    localparam int CMAX = 15;

    logic clk = 0, rst_n = 0;
    logic [N_ALGO-1:0] algo_bits = '0;
    logic [N_TECH-1:0] tech_bits = '0;
    logic seg_strobe = 0, cfg_we = 0;
    logic [1:0] cfg_sel = '0;
    logic [IDX_W-1:0] cfg_idx = '0, rd_idx = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [CNT_W-1:0] rd_rate;
    logic [N_OUT-1:0] final_or;

    int errors = 0, checks = 0;
    int m_fac [N_IN], m_pc [N_IN], m_cnt [N_IN], m_snap [N_IN];
    bit [N_OUT-1:0] m_en [N_IN];
    bit [N_OUT-1:0] m_veto [N_TECH];
    bit [N_IN-1:0] m_inq = '0;
    bit [N_OUT-1:0] m_or = '0;

    always #2.5 clk = ~clk;

    fdl_final_decision #(.N_ALGO(N_ALGO), .N_TECH(N_TECH), .N_OUT(N_OUT),
        .PS_W(PS_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .algo_bits(algo_bits), .tech_bits(tech_bits),
        .seg_strobe(seg_strobe), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
        .rd_rate(rd_rate), .final_or(final_or));

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    // model step for one clock edge, following R2..R9
    task automatic model_edge(input bit [N_IN-1:0] v, input bit s, input bit we,
                              input int sel, input int idx, input int data);
        bit [N_IN-1:0] pv;
        bit [N_OUT-1:0] no;
        for (int i = 0; i < N_IN; i++)
            pv[i] = m_inq[i] && m_fac[i] != 0 && m_pc[i] == m_fac[i] - 1;
        for (int k = 0; k < N_OUT; k++) begin
            bit a = 0, vt = 0;
            for (int i = 0; i < N_IN; i++) a |= pv[i] && m_en[i][k];
            for (int j = 0; j < N_TECH; j++) vt |= m_inq[N_ALGO+j] && m_veto[j][k];
            no[k] = a && !vt;
        end
        for (int i = 0; i < N_IN; i++) begin
            if (m_inq[i] && m_fac[i] != 0) m_pc[i] = pv[i] ? 0 : m_pc[i] + 1;
            if (s) begin
                m_snap[i] = m_cnt[i];
                m_cnt[i] = m_inq[i] ? 1 : 0;
            end else if (m_inq[i] && m_cnt[i] < CMAX) m_cnt[i]++;
        end
        if (we) begin
            if (sel == 0 && idx < N_IN) begin m_fac[idx] = data & 15; m_pc[idx] = 0; end
            if (sel == 1 && idx < N_IN) m_en[idx] = N_OUT'(data);
            if (sel == 2 && idx < N_TECH) m_veto[idx] = N_OUT'(data);
        end
        m_inq = v;
        m_or = no;
    endtask

    task automatic step(input bit [N_IN-1:0] v, input bit s, input bit we,
                        input int sel, input int idx, input int data,
                        input int rd, input string tag);
        @(negedge clk);
        algo_bits = v[N_ALGO-1:0];
        tech_bits = v[N_IN-1:N_ALGO];
        seg_strobe = s;
        cfg_we = we;
        cfg_sel = 2'(sel);
        cfg_idx = IDX_W'(idx);
        cfg_wdata = DATA_W'(data);
        rd_idx = IDX_W'(rd);
        @(posedge clk);
        model_edge(v, s, we, sel, idx, data);
        #1;
        checks++;
        if (final_or !== m_or) begin
            errors++;
            $display("FAIL %s R4 final_or got %b exp %b", tag, final_or, m_or);
        end
        checks++;
        if (int'(rd_rate) != m_snap[rd]) begin
            errors++;
            $display("FAIL %s R7 rd_rate[%0d] got %0d exp %0d", tag, rd, rd_rate, m_snap[rd]);
        end
    endtask

    task automatic wr(input int sel, input int idx, input int data);
        step('0, 0, 1, sel, idx, data, 0, "R9 cfg");
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < N_IN; i++) step('0, 0, 0, 0, 0, 0, i, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N_IN; i++) begin
            m_fac[i] = 0; m_pc[i] = 0; m_cnt[i] = 0; m_snap[i] = 0; m_en[i] = '0;
        end
        for (int j = 0; j < N_TECH; j++) m_veto[j] = '0;
        repeat (3) @(posedge clk);
        // R1: reset state
        for (int i = 0; i < N_IN; i++) begin
            rd_idx = IDX_W'(i);
            #0.1;
            checks++;
            if (rd_rate !== '0 || final_or !== '0) begin
                errors++;
                $display("FAIL R1 reset idx %0d rd_rate %0d final_or %b exp 0 0", i, rd_rate, final_or);
            end
        end
        @(negedge clk) rst_n = 1;
        // R1: zero masks and factors keep everything low
        for (int c = 0; c < 6; c++) step('1, 0, 0, 0, 0, 0, 0, "R1 masks");

        // R2: factor 3 on bit 1 fires on every third asserted cycle
        wr(0, 1, 3); wr(1, 1, 4'b0001);
        for (int c = 0; c < 10; c++) step(N_IN'(c % 4 == 3 ? 0 : 2), 0, 0, 0, 0, 0, 0, "R2 prescale");
        wr(0, 1, 3);
        for (int c = 0; c < 7; c++) step(N_IN'(2), 0, 0, 0, 0, 0, 0, "R2 rewrite");
        // R3: factor 0 on bit 2 enabled on output 1
        wr(1, 2, 4'b0010);
        for (int c = 0; c < 6; c++) step(N_IN'(4), 0, 0, 0, 0, 0, 0, "R3 blocked");
        // R5: bit 0 on output 2, vetoed by tech 0 whose own factor is 0
        wr(0, 0, 1); wr(1, 0, 4'b0100); wr(2, 0, 4'b0100);
        for (int c = 0; c < 8; c++)
            step(N_IN'(1) | (c % 2 == 0 ? N_IN'(1) << N_ALGO : '0), 0, 0, 0, 0, 0, 0, "R5 veto");
        // R6 R7 R8: saturate bit 0, then strobe
        step('0, 1, 0, 0, 0, 0, 0, "R7 strobe");
        for (int c = 0; c < 20; c++) step(N_IN'(1), 0, 0, 0, 0, 0, 0, "R6 count");
        step(N_IN'(1), 1, 0, 0, 0, 0, 0, "R8 saturate strobe");
        step('0, 1, 0, 0, 0, 0, 0, "R7 restart");
        sweep("R8 readback");

        // random phase: R2 R4 R5 R6 R7 R9
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < N_IN; i++) begin
                wr(0, i, int'($urandom_range(0, 4)));
                wr(1, i, int'($urandom_range(0, 15)));
            end
            for (int j = 0; j < N_TECH; j++)
                wr(2, j, ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : 0);
            for (int c = 0; c < 60; c++) begin
                bit [N_IN-1:0] v = N_IN'($urandom) & N_IN'($urandom);
                step(v, $urandom_range(0, 24) == 0, 0, 0, 0, 0,
                     int'($urandom_range(0, N_IN-1)), "R6 random");
            end
            step('0, 1, 0, 0, 0, 0, 0, "R7 random strobe");
            sweep("R7 random readback");
        end
        summary();
        $finish;
    end
endmodule